// File: doc/BRIEF.md
# VLAN Tag Insert/Delete Engine

This block sits in a byte-wide transmit path, after the frame buffer and before the MAC. It edits the 802.1Q tag of each frame as the bytes go past. Each frame arrives on a valid/ready stream with start and end markers. With the first byte come a 2-bit edit command and a 16-bit tag control value. The block latches both and applies them to that frame only.

Four edits are available:
- Pass: the frame goes out untouched.
- Insert: a new tag (81h, 00h, then the control value high byte first) goes in directly after the two addresses.
- Delete: an existing tag is removed.
- Replace: the control field of an existing tag is overwritten.

Delete and replace act only when bytes 12 and 13 hold the tag type 8100h. Otherwise the frame is left as it is and a one-cycle miss flag is raised. The 4-byte change in length is absorbed inside the block: it stalls the input side on insert and swallows input bytes on delete. The start and end markers stay on the first and last bytes of the edited frame.

Upstream must meet three conditions. Frames sent with delete must be at least 17 bytes long. Input data must stay stable while valid is high and ready is low. Frame check sequence and padding are produced downstream.

Top module: `vlan_tag_editor`

## Requirements
- R1: After reset, out_valid and tag_miss are low and in_ready is high.
- R2: Command 00 sends every byte of the frame out unchanged, in order, even when the frame carries a tag.
- R3: Command 10 on a frame of 13 or more bytes outputs bytes 0 to 11, then 81h, 00h, the control value high byte, the control value low byte, then input byte 12 onward. The output is 4 bytes longer than the input.
- R4: During an insert with no output back-pressure, in_ready is low for exactly 4 cycles while in_valid is high, and for no other cycle of that frame.
- R5: Command 01, when input bytes 12 and 13 are 81h and 00h, removes input bytes 12 to 15. out_valid is never asserted for them, and the output is 4 bytes shorter.
- R6: Command 11, when input bytes 12 and 13 are 81h and 00h, outputs the frame with bytes 14 and 15 replaced by the control value (high byte first). The length is unchanged.
- R7: Command 01 or 11 on a frame of 14 or more bytes whose bytes 12 and 13 are not 81h 00h outputs the frame unchanged and raises tag_miss for exactly one cycle. tag_miss stays low for every other frame.
- R8: Command 10 on a frame of 12 bytes or fewer outputs the frame unchanged.
- R9: out_sof is high only on the first output byte of a frame, and out_eof only on its last.
- R10: While out_valid is high and out_ready is low, out_valid, out_data and the markers hold their values. Under back-pressure no byte is lost or repeated.
- R11: The command and control value are taken with the start byte, so back-to-back frames each get their own edit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input byte present |
| in_ready | output | 1 | Input byte accepted this cycle |
| in_data | input | 8 | Input byte |
| in_sof | input | 1 | First byte of a frame |
| in_eof | input | 1 | Last byte of a frame |
| in_cmd | input | 2 | Edit command, sampled with the first byte: 00 pass, 01 delete, 10 insert, 11 replace |
| in_tci | input | 16 | Tag control value, sampled with the first byte |
| out_valid | output | 1 | Output byte present |
| out_ready | input | 1 | Downstream takes the output byte |
| out_data | output | 8 | Output byte |
| out_sof | output | 1 | First byte of an edited frame |
| out_eof | output | 1 | Last byte of an edited frame |
| tag_miss | output | 1 | One-cycle pulse: delete or replace found no 8100h tag |

## Verification
The bench builds the expected byte sequence for each command from the rules above. It compares the output length, every byte and the marker positions. This catches an insert placed one byte off, a control value with its bytes swapped, or a delete that drops the wrong four bytes.

It counts input stalls during an insert, so a design that stalls for three or five cycles fails. It also sends frames whose bytes 12 and 13 hold a different type. A design that skipped the type check would then strip or overwrite real payload, and one that pulsed the miss flag on the wrong frames would also be caught.

Random output back-pressure is applied during insert, delete and replace. This exposes a design that advances its held byte while the output is stalled. A 12-byte insert frame and back-to-back frames with changing commands check that short frames are left alone and that the command is taken per frame.

// File: rtl/vlan_tag_editor.sv
module vlan_tag_editor #(
  parameter logic [15:0] TPID = 16'h8100
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  output logic        in_ready,
  input  logic [7:0]  in_data,
  input  logic        in_sof,
  input  logic        in_eof,
  input  logic [1:0]  in_cmd,
  input  logic [15:0] in_tci,
  output logic        out_valid,
  input  logic        out_ready,
  output logic [7:0]  out_data,
  output logic        out_sof,
  output logic        out_eof,
  output logic        tag_miss
);

  localparam logic [1:0] CMD_PASS = 2'b00;
  localparam logic [1:0] CMD_DEL  = 2'b01;
  localparam logic [1:0] CMD_INS  = 2'b10;
  localparam logic [1:0] CMD_REP  = 2'b11;
  localparam int         IW       = 5;
  localparam logic [IW-1:0] IDX_SAT = IW'(16);

  typedef enum logic [2:0] {S_NORM, S_INS, S_CHK12, S_CHK13, S_DROP, S_REPL} st_t;

  st_t          st;
  logic [IW-1:0] idx;
  logic [1:0]   gk;
  logic [1:0]   cmd_q;
  logic [15:0]  tci_q;
  logic [7:0]   h0;
  logic         ld, acc, tag_ok, del_hit;
  logic         e_vld, e_sof, e_eof;
  logic [7:0]   e_dat, gen_byte;
  logic [IW-1:0] cur;

  assign ld      = !out_valid || out_ready;
  assign acc     = in_valid && in_ready;
  assign cur     = in_sof ? '0 : idx;
  assign tag_ok  = ({h0, in_data} == TPID) && !in_eof;
  assign del_hit = tag_ok && (cmd_q == CMD_DEL);

  always_comb begin
    case (gk)
      2'd0:    gen_byte = TPID[15:8];
      2'd1:    gen_byte = TPID[7:0];
      2'd2:    gen_byte = tci_q[15:8];
      default: gen_byte = tci_q[7:0];
    endcase
  end

  always_comb begin
    in_ready = 1'b0;
    e_vld    = 1'b0;
    e_dat    = in_data;
    e_sof    = in_sof;
    e_eof    = in_eof;
    case (st)
      S_NORM: begin
        in_ready = ld;
        e_vld    = in_valid && ld;
      end
      S_INS: begin
        e_vld = ld;
        e_dat = gen_byte;
        e_sof = 1'b0;
        e_eof = 1'b0;
      end
      S_CHK12: begin
        in_ready = ld;
        e_vld    = in_valid && ld && in_eof;
      end
      S_CHK13: begin
        in_ready = in_valid && del_hit;
        e_vld    = in_valid && ld && !del_hit;
        e_dat    = h0;
        e_sof    = 1'b0;
        e_eof    = 1'b0;
      end
      S_DROP: in_ready = 1'b1;
      S_REPL: begin
        in_ready = ld;
        e_vld    = in_valid && ld;
        if (idx == IW'(14)) e_dat = tci_q[15:8];
        else if (idx == IW'(15)) e_dat = tci_q[7:0];
      end
      default: in_ready = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= S_NORM;
      idx       <= '0;
      gk        <= '0;
      cmd_q     <= CMD_PASS;
      tci_q     <= '0;
      h0        <= '0;
      out_valid <= 1'b0;
      out_data  <= '0;
      out_sof   <= 1'b0;
      out_eof   <= 1'b0;
      tag_miss  <= 1'b0;
    end else begin
      tag_miss <= 1'b0;

      if (e_vld) begin
        out_valid <= 1'b1;
        out_data  <= e_dat;
        out_sof   <= e_sof;
        out_eof   <= e_eof;
      end else if (out_ready) begin
        out_valid <= 1'b0;
      end

      if (acc) begin
        if (in_sof) begin
          cmd_q <= in_cmd;
          tci_q <= in_tci;
        end
        if (in_eof) idx <= '0;
        else if (cur == IDX_SAT) idx <= IDX_SAT;
        else idx <= cur + IW'(1);
      end

      case (st)
        S_NORM:
          if (acc && !in_eof && cur == IW'(11)) begin
            if (cmd_q == CMD_INS) begin
              st <= S_INS;
              gk <= '0;
            end else if (cmd_q == CMD_DEL || cmd_q == CMD_REP) begin
              st <= S_CHK12;
            end
          end
        S_INS:
          if (ld) begin
            gk <= gk + 2'd1;
            if (gk == 2'd3) st <= S_NORM;
          end
        S_CHK12:
          if (acc) begin
            h0 <= in_data;
            st <= in_eof ? S_NORM : S_CHK13;
          end
        S_CHK13:
          if (in_valid) begin
            if (del_hit) st <= S_DROP;
            else if (ld) begin
              st       <= (tag_ok && cmd_q == CMD_REP) ? S_REPL : S_NORM;
              tag_miss <= !tag_ok;
            end
          end
        S_DROP:
          if (acc && (in_eof || idx == IW'(15))) st <= S_NORM;
        S_REPL:
          if (acc && (in_eof || idx == IW'(15))) st <= S_NORM;
        default: st <= S_NORM;
      endcase
    end
  end

endmodule

// File: rtl/vlan_tag_editor_chk.sv
module vlan_tag_editor_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       in_valid,
  input logic       in_ready,
  input logic       in_sof,
  input logic       in_eof,
  input logic [1:0] in_cmd,
  input logic       out_valid,
  input logic       out_ready,
  input logic [7:0] out_data,
  input logic       out_sof,
  input logic       out_eof,
  input logic       tag_miss
);

  logic [15:0] ic, oc, in_len_now, out_len_now, last_len;
  logic [1:0]  f_cmd, last_cmd;
  logic        in_hs, out_hs, out_end;

  assign in_hs       = in_valid && in_ready;
  assign out_hs      = out_valid && out_ready;
  assign out_end     = out_hs && out_eof;
  assign in_len_now  = (in_sof ? 16'd0 : ic) + 16'd1;
  assign out_len_now = (out_sof ? 16'd0 : oc) + 16'd1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ic       <= '0;
      oc       <= '0;
      f_cmd    <= '0;
      last_cmd <= '0;
      last_len <= '0;
    end else begin
      if (in_hs) begin
        ic <= in_len_now;
        if (in_sof) f_cmd <= in_cmd;
        if (in_eof) begin
          last_len <= in_len_now;
          last_cmd <= in_sof ? in_cmd : f_cmd;
        end
      end
      if (out_hs) oc <= out_len_now;
    end
  end

  a_r10_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_sof) && $stable(out_eof)));

  a_r7_miss_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    tag_miss |=> !tag_miss);

  a_r2_pass_len: assert property (@(posedge clk) disable iff (!rst_n)
    (out_end && last_cmd == 2'b00) |-> (out_len_now == last_len));

  a_r3_insert_len: assert property (@(posedge clk) disable iff (!rst_n)
    (out_end && last_cmd == 2'b10) |->
      (out_len_now == ((last_len > 16'd12) ? last_len + 16'd4 : last_len)));

  a_r5_delete_len: assert property (@(posedge clk) disable iff (!rst_n)
    (out_end && last_cmd == 2'b01) |->
      (out_len_now == last_len || out_len_now + 16'd4 == last_len));

  a_r6_replace_len: assert property (@(posedge clk) disable iff (!rst_n)
    (out_end && last_cmd == 2'b11) |-> (out_len_now == last_len));

endmodule

bind vlan_tag_editor vlan_tag_editor_chk u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .in_sof(in_sof), .in_eof(in_eof), .in_cmd(in_cmd),
  .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
  .out_sof(out_sof), .out_eof(out_eof), .tag_miss(tag_miss)
);

// File: tb/tb_vlan_tag_editor.sv
module tb_vlan_tag_editor;
  logic clk = 1'b0, rst_n = 1'b0;
  logic in_valid = 1'b0, in_sof = 1'b0, in_eof = 1'b0, out_ready = 1'b0;
  logic [7:0] in_data = '0;
  logic [1:0] in_cmd = '0;
  logic [15:0] in_tci = '0;
  logic in_ready, out_valid, out_sof, out_eof, tag_miss;
  logic [7:0] out_data;

  int checks = 0, errors = 0;
  logic [7:0] lf = 8'h5b;
  logic [7:0] fin [0:63];
  logic [7:0] fexp [0:71];
  logic [7:0] got [0:99];
  logic gsof [0:99];
  logic geof [0:99];

  always #2 clk = ~clk;

  vlan_tag_editor dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_sof(in_sof), .in_eof(in_eof), .in_cmd(in_cmd),
    .in_tci(in_tci), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data), .out_sof(out_sof), .out_eof(out_eof), .tag_miss(tag_miss)
  );

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic run_frame(input logic [1:0] cmd, input logic [15:0] tci, input int len,
                           input logic [15:0] tag, input bit bp, input int want_stalls,
                           input string req);
    int elen, ii, oc, cyc, misses, stalls, bad, bad_at, sof_bad, eof_bad;
    bit pend, done, match;
    for (int i = 0; i < len; i++) fin[i] = 8'((i * 13 + len * 7 + 3) & 255);
    if (len > 12) fin[12] = tag[15:8];
    if (len > 13) fin[13] = tag[7:0];
    if (len > 14) fin[14] = 8'hc3;
    if (len > 15) fin[15] = 8'h3c;
    match = (len > 14) && fin[12] == 8'h81 && fin[13] == 8'h00;
    elen = 0;
    for (int i = 0; i < len; i++) begin
      if (cmd == 2'b10 && i == 12) begin
        fexp[elen] = 8'h81; fexp[elen+1] = 8'h00;
        fexp[elen+2] = tci[15:8]; fexp[elen+3] = tci[7:0];
        elen += 4;
      end
      if (cmd == 2'b01 && match && i >= 12 && i <= 15) continue;
      if (cmd == 2'b11 && match && i == 14) fexp[elen] = tci[15:8];
      else if (cmd == 2'b11 && match && i == 15) fexp[elen] = tci[7:0];
      else fexp[elen] = fin[i];
      elen++;
    end
    ii = 0; oc = 0; cyc = 0; misses = 0; stalls = 0; pend = 0; done = 0;
    while (!done && cyc < 3000) begin
      @(negedge clk);
      cyc++;
      lf = {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
      if (!pend) in_valid = (ii < len) && !(bp && lf[6]);
      if (in_valid) begin
        in_data = fin[ii]; in_sof = (ii == 0); in_eof = (ii == len - 1);
        in_cmd = cmd; in_tci = tci;
      end
      out_ready = bp ? (lf[1] | lf[2]) : 1'b1;
      #1;
      if (tag_miss) misses++;
      if (in_valid && !in_ready) stalls++;
      if (in_valid && in_ready) begin ii++; pend = 0; end
      else pend = in_valid;
      if (out_valid && out_ready && oc < 100) begin
        got[oc] = out_data; gsof[oc] = out_sof; geof[oc] = out_eof;
        oc++;
        if (out_eof) done = 1;
      end
    end
    in_valid = 1'b0;
    chk(done, req, "frame completed", int'(done), 1);
    chk(oc == elen, req, "output length", oc, elen);
    bad = 0; bad_at = -1; sof_bad = 0; eof_bad = 0;
    for (int i = 0; i < oc && i < elen; i++) begin
      if (got[i] !== fexp[i]) begin bad++; if (bad_at < 0) bad_at = i; end
      if (gsof[i] !== (i == 0)) sof_bad++;
      if (geof[i] !== (i == oc - 1)) eof_bad++;
    end
    if (bad_at < 0) chk(1'b1, req, "byte content", 0, 0);
    else chk(1'b0, req, $sformatf("byte %0d", bad_at), int'(got[bad_at]), int'(fexp[bad_at]));
    chk(sof_bad == 0 && eof_bad == 0, "R9", "misplaced markers", sof_bad + eof_bad, 0);
    chk(misses == ((cmd[0] && len >= 14 && !match) ? 1 : 0), "R7", "tag_miss pulses", misses,
        (cmd[0] && len >= 14 && !match) ? 1 : 0);
    if (want_stalls >= 0) chk(stalls == want_stalls, "R4", "input stall cycles", stalls, want_stalls);
  endtask

  task automatic t_reset();
    @(negedge clk); #1;
    chk(!out_valid && !tag_miss && in_ready, "R1", "reset state",
        {out_valid, tag_miss, in_ready}, 3'b001);
  endtask

  task automatic t_pass();      run_frame(2'b00, 16'h1234, 20, 16'h8100, 0, -1, "R2"); endtask
  task automatic t_insert();    run_frame(2'b10, 16'hbeef, 24, 16'h0800, 0, 4, "R3"); endtask
  task automatic t_insert_bp(); run_frame(2'b10, 16'h4321, 40, 16'h0800, 1, -1, "R10"); endtask
  task automatic t_insert_13(); run_frame(2'b10, 16'h00ff, 13, 16'h0800, 0, 4, "R3"); endtask
  task automatic t_insert_short(); run_frame(2'b10, 16'h7777, 12, 16'h0000, 0, 0, "R8"); endtask
  task automatic t_delete();    run_frame(2'b01, 16'h0000, 30, 16'h8100, 0, 0, "R5"); endtask
  task automatic t_delete_bp(); run_frame(2'b01, 16'h0000, 17, 16'h8100, 1, -1, "R5"); endtask
  task automatic t_delete_miss(); run_frame(2'b01, 16'h0000, 25, 16'h88a8, 0, -1, "R7"); endtask
  task automatic t_replace();   run_frame(2'b11, 16'ha55a, 22, 16'h8100, 0, -1, "R6"); endtask
  task automatic t_replace_bp(); run_frame(2'b11, 16'h0f0e, 33, 16'h8100, 1, -1, "R6"); endtask
  task automatic t_replace_miss(); run_frame(2'b11, 16'h1111, 20, 16'h0800, 0, -1, "R7"); endtask
  task automatic t_back_to_back();
    run_frame(2'b10, 16'h2468, 18, 16'h0800, 1, -1, "R11");
    run_frame(2'b01, 16'h0000, 19, 16'h8100, 1, -1, "R11");
    run_frame(2'b00, 16'hffff, 16, 16'h8100, 1, -1, "R11");
    run_frame(2'b11, 16'h9abc, 21, 16'h8100, 1, -1, "R11");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got %0d expected %0d", 1, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_pass();
    t_insert();
    t_insert_bp();
    t_insert_13();
    t_insert_short();
    t_delete();
    t_delete_bp();
    t_delete_miss();
    t_replace();
    t_replace_bp();
    t_replace_miss();
    t_back_to_back();
    repeat (4) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule